// File: doc/BRIEF.md
# Power partition gating register block

This block is a small register slave that switches a set of power partitions on and off and releases their isolation clamps. Software requests a change of power state by writing a partition index with a start qualifier to a toggle register. The block then drives the partition's switch enable at once. It reports the partition as powered in a status register only after a fixed ramp delay, counted in clock cycles. Software polls that status word to learn when the new state has taken effect.

A separate clamp-release register frees the isolation clamp of a partition once that partition is powered. For backward compatibility, the clamp bits of two chosen partitions (the PCIe partition and the video decoder partition) are exchanged. A power-down request puts the clamp back at once, so every power-up needs a new release. Reads are combinational on the address. Only the status word returns data.

Top module: `pwr_part_ctrl`

## Requirements
- R1: While reset is active, and after it, all partitions are off, the status word reads 0, `pwr_en_o` is all zeros and `clamp_o` is all ones (1 = clamped).
- R2: A read at offset 0x38 returns the status word. Bit i is 1 when partition i is powered, and the bits above N_PART-1 are 0.
- R3: A write at offset 0x30 with bit 8 set and an index field (bits 7:0) below N_PART is a toggle. It inverts that partition's `pwr_en_o` bit in the cycle after the write edge.
- R4: After a toggle written at clock edge k, the status bit of that partition keeps its old value through edge k+RAMP_CYC-1. It takes the new value at edge k+RAMP_CYC.
- R5: A write at 0x30 with bit 8 clear, or with an index field of N_PART or more, changes no output and no status bit.
- R6: A toggle aimed at a partition whose ramp is still in progress is ignored.
- R7: A write at 0x34 releases clamps. Each set bit j below N_PART clears the clamp of its mapped partition, but only if that partition is powered and not ramping. Other clamps are unchanged.
- R8: Bit PCIE_IDX of the clamp-release word maps to partition VDEC_IDX, and bit VDEC_IDX maps to partition PCIE_IDX. Every other bit maps to the partition of the same number.
- R9: An accepted power-down toggle sets that partition's clamp in the cycle after the write. An unpowered partition is always clamped, so each power-up needs a fresh release.
- R10: A read at any offset other than 0x38, including 0x30 and 0x34, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | AW | Byte offset of the access |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| pwr_en_o | output | N_PART | Switch enable per partition |
| clamp_o | output | N_PART | Isolation clamp per partition, 1 = clamped |

## Verification
The hardest state to reach from the ports is a clamp release or a second toggle that lands while the partition's ramp is still running. A partition is also hard to unclamp at random, because it must first be powered and then left idle. Directed sequences therefore hit the ramp window on purpose. They release the exchanged pair in both directions and power a partition down and back up to show the clamp returns. A long random phase then follows. It mixes toggles, releases and status reads, with many idle reads so that ramps finish and clamps can be released.

// File: rtl/pwr_part_pkg.sv
`timescale 1ns/1ps
package pwr_part_pkg;
  localparam int OFS_TOGGLE  = 'h30;
  localparam int OFS_UNCLAMP = 'h34;
  localparam int OFS_STATUS  = 'h38;
  localparam int START_BIT   = 8;
  localparam int IDX_W       = 8;
endpackage

// File: rtl/pwr_part_dec.sv
`timescale 1ns/1ps
module pwr_part_dec
  import pwr_part_pkg::*;
#(
  parameter int N_PART   = 8,
  parameter int PCIE_IDX = 3,
  parameter int VDEC_IDX = 1,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N_PART-1:0] stat_i,
  output logic [N_PART-1:0] tog_o,
  output logic [N_PART-1:0] unclamp_o,
  output logic [DW-1:0]     rdata_o
);
  logic [IDX_W-1:0]  idx_w;
  logic [N_PART-1:0] map_w;
  logic              tog_wr, clr_wr;

  assign idx_w  = wdata_i[IDX_W-1:0];
  assign tog_wr = wr_en_i && (addr_i == AW'(OFS_TOGGLE)) && wdata_i[START_BIT];
  assign clr_wr = wr_en_i && (addr_i == AW'(OFS_UNCLAMP));

  // legacy exchange of two clamp bits
  for (genvar j = 0; j < N_PART; j++) begin : g_map
    localparam int P = (j == PCIE_IDX) ? VDEC_IDX :
                       (j == VDEC_IDX) ? PCIE_IDX : j;
    assign map_w[P] = wdata_i[j];
  end

  for (genvar i = 0; i < N_PART; i++) begin : g_tog
    assign tog_o[i] = tog_wr && (idx_w == IDX_W'(i));
  end

  assign unclamp_o = clr_wr ? map_w : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_STATUS)) rdata_o[N_PART-1:0] = stat_i;
  end
endmodule

// File: rtl/pwr_part_slot.sv
`timescale 1ns/1ps
module pwr_part_slot #(
  parameter int RAMP_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  input  logic unclamp_i,
  output logic pwr_en_o,
  output logic stat_o,
  output logic clamp_o
);
  localparam int CNT_W = $clog2(RAMP_CYC + 1);

  logic             tgt_q, stat_q, busy_q, clamp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= 1'b0;
      stat_q  <= 1'b0;
      busy_q  <= 1'b0;
      clamp_q <= 1'b1;
      cnt_q   <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        stat_q <= tgt_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (tog_i) begin
      tgt_q  <= ~stat_q;
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RAMP_CYC - 1);
      if (stat_q) clamp_q <= 1'b1;  // re-isolate on power-down
    end else if (unclamp_i && stat_q) begin
      clamp_q <= 1'b0;
    end
  end

  assign pwr_en_o = tgt_q;
  assign stat_o   = stat_q;
  assign clamp_o  = clamp_q;
endmodule

// File: rtl/pwr_part_ctrl.sv
`timescale 1ns/1ps
module pwr_part_ctrl #(
  parameter int N_PART   = 8,
  parameter int RAMP_CYC = 12,
  parameter int PCIE_IDX = 3,
  parameter int VDEC_IDX = 1,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_PART-1:0] pwr_en_o,
  output logic [N_PART-1:0] clamp_o
);
  logic [N_PART-1:0] stat_w, tog_w, unclamp_w;

  pwr_part_dec #(
    .N_PART(N_PART), .PCIE_IDX(PCIE_IDX), .VDEC_IDX(VDEC_IDX), .AW(AW), .DW(DW)
  ) i_dec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .stat_i   (stat_w),
    .tog_o    (tog_w),
    .unclamp_o(unclamp_w),
    .rdata_o  (rdata_o)
  );

  for (genvar i = 0; i < N_PART; i++) begin : g_slot
    pwr_part_slot #(.RAMP_CYC(RAMP_CYC)) i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tog_i    (tog_w[i]),
      .unclamp_i(unclamp_w[i]),
      .pwr_en_o (pwr_en_o[i]),
      .stat_o   (stat_w[i]),
      .clamp_o  (clamp_o[i])
    );
  end
endmodule

// File: rtl/pwr_part_chk.sv
`timescale 1ns/1ps
module pwr_part_chk
  import pwr_part_pkg::*;
#(
  parameter int N_PART = 8,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [N_PART-1:0] pwr_en_o,
  input logic [N_PART-1:0] clamp_o,
  input logic [N_PART-1:0] stat_i
);
  AST_NOSTART_NO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(OFS_TOGGLE) && !wdata_i[START_BIT]) |=> $stable(pwr_en_o)); // R5

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != AW'(OFS_STATUS)) |-> (rdata_o == '0)); // R10

  AST_OFF_IS_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~stat_i & ~clamp_o) == '0)); // R9

  AST_RELEASE_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(clamp_o) & ~clamp_o & ~$past(stat_i)) == '0)); // R7

  AST_STATUS_FOLLOWS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((stat_i ^ $past(stat_i)) & (stat_i ^ $past(pwr_en_o))) == '0)); // R4
endmodule

bind pwr_part_ctrl pwr_part_chk #(.N_PART(N_PART), .AW(AW), .DW(DW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pwr_en_o(pwr_en_o),
  .clamp_o (clamp_o),
  .stat_i  (stat_w)
);

// File: tb/test_pwr_part_ctrl.sv
`timescale 1ns/1ps
module test_pwr_part_ctrl;
  localparam int N  = 8;
  localparam int RC = 12;
  localparam int PI = 3;
  localparam int VI = 1;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_TOG = 8'h30, A_CLR = 8'h34, A_STA = 8'h38;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = A_STA;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [N-1:0]  pwr_en_o, clamp_o;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_tgt, m_stat, m_clamp;
  int m_rem [N];

  always #5 clk_i = ~clk_i;

  pwr_part_ctrl #(.N_PART(N), .RAMP_CYC(RC), .PCIE_IDX(PI), .VDEC_IDX(VI), .AW(AW), .DW(DW))
    i_pwr_part_ctrl (.*);

  function automatic int map_bit(int j);
    return (j == PI) ? VI : (j == VI) ? PI : j;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [N-1:0] ps = m_stat;
    int pr [N];
    for (int i = 0; i < N; i++) pr[i] = m_rem[i];
    for (int i = 0; i < N; i++)
      if (pr[i] > 0) begin
        m_rem[i] = pr[i] - 1;
        if (m_rem[i] == 0) m_stat[i] = m_tgt[i];
      end
    if (we && a == A_TOG && d[8] && d[7:0] < N) begin
      int k = int'(d[7:0]);
      if (pr[k] == 0) begin
        m_tgt[k] = ~ps[k];
        m_rem[k] = RC;
        if (ps[k]) m_clamp[k] = 1'b1;
      end
    end
    if (we && a == A_CLR)
      for (int j = 0; j < N; j++)
        if (d[j]) begin
          int p = map_bit(j);
          if (ps[p] && pr[p] == 0) m_clamp[p] = 1'b0;
        end
  endtask

  task automatic op(logic we, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    @(negedge clk_i);
    wr_en_i = we; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    model_edge(we, a, d);
    #2;
    chk({tag, " pwr_en"}, 64'(pwr_en_o), 64'(m_tgt));
    chk({tag, " clamp"},  64'(clamp_o),  64'(m_clamp));
    chk({tag, " rdata"},  64'(rdata_o),  (a == A_STA) ? 64'(m_stat) : 64'd0);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) op(1'b0, A_STA, '0, tag);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_tgt = '0; m_stat = '0; m_clamp = '1;
    for (int i = 0; i < N; i++) m_rem[i] = 0;
    #23;
    chk("R1 reset rdata", 64'(rdata_o), 64'd0);
    chk("R1 reset pwr_en", 64'(pwr_en_o), 64'd0);
    chk("R1 reset clamp", 64'(clamp_o), 64'(N'('1)));
    rst_ni = 1'b1;
    idle(2, "R1 R2");

    op(1'b1, A_TOG, 32'h0000_0002, "R5 no start");
    op(1'b1, A_TOG, 32'h0000_0109, "R5 index range");
    chk("R5 pwr_en untouched", 64'(pwr_en_o), 64'd0);

    op(1'b1, A_TOG, 32'h0000_0100, "R3 toggle p0");
    chk("R3 pwr_en p0", 64'(pwr_en_o[0]), 64'd1);
    op(1'b1, A_CLR, 32'h1, "R7 release while ramping");
    chk("R7 still clamped", 64'(clamp_o[0]), 64'd1);
    op(1'b1, A_TOG, 32'h0000_0100, "R6 toggle during ramp");
    chk("R6 pwr_en stays", 64'(pwr_en_o[0]), 64'd1);
    idle(RC - 3, "R4 ramp");
    chk("R4 status still old", 64'(rdata_o[0]), 64'd0);
    idle(1, "R4 ramp end");
    chk("R4 status new", 64'(rdata_o[0]), 64'd1);
    op(1'b1, A_CLR, 32'h1, "R7 release p0");
    chk("R7 p0 released", 64'(clamp_o[0]), 64'd0);

    op(1'b1, A_TOG, 32'(9'h100 | VI), "R3 toggle vdec");
    op(1'b1, A_TOG, 32'(9'h100 | PI), "R3 toggle pcie");
    idle(RC, "R4");
    op(1'b1, A_CLR, 32'(1 << PI), "R8 pcie bit");
    chk("R8 vdec released", 64'(clamp_o[VI]), 64'd0);
    chk("R8 pcie kept", 64'(clamp_o[PI]), 64'd1);
    op(1'b1, A_CLR, 32'(1 << VI), "R8 vdec bit");
    chk("R8 pcie released", 64'(clamp_o[PI]), 64'd0);

    op(1'b1, A_TOG, 32'h0000_0100, "R9 power down p0");
    chk("R9 reclamped", 64'(clamp_o[0]), 64'd1);
    idle(RC, "R9");
    op(1'b1, A_TOG, 32'h0000_0100, "R9 power up p0");
    idle(RC, "R9");
    chk("R9 needs release", 64'(clamp_o[0]), 64'd1);

    op(1'b0, A_TOG, '0, "R10 read toggle");
    op(1'b0, A_CLR, '0, "R10 read clamp");
    op(1'b0, 8'h3C, '0, "R10 read other");
    op(1'b0, A_STA, '0, "R2 read status");

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 6;
      logic [DW-1:0] d;
      case (r)
        0, 1: begin
          d = 32'($urandom % (N + 3));
          if ($urandom % 10 < 8) d[8] = 1'b1;
          op(1'b1, A_TOG, d, "R3 R4 R6 rand");
        end
        2: op(1'b1, A_CLR, 32'(1 << ($urandom % N)) | (($urandom % 4 == 0) ? 32'($urandom) & 32'hFF : 32'h0),
              "R7 R8 rand");
        3: op(1'b0, 8'($urandom), '0, "R10 rand");
        default: op(1'b0, A_STA, '0, "R2 R9 rand");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule